// File: doc/BRIEF.md
# MII Management Frame Controller

This block lets software run PHY management accesses through a single 32-bit frame register. Software composes the whole management frame in one word (start code, opcode, PHY address, register address, turnaround and data) and writes it. A well-formed frame to the wired PHY address starts a serial transaction on MDC/MDIO: 32 preamble ones followed by the 32 frame bits. Completion is reported by setting bit 16 of the frame register, and for a read the low 16 bits are replaced with the PHY's reply. Software polls bit 16 rather than a separate busy flag.

A frame that is malformed or addressed to another PHY completes at once: it is stored with bit 16 set and the bus stays idle. A write to the frame register while a transaction is running is dropped, and a one-cycle error pulse is raised. The block also holds a configuration register with two read-only presence bits, and a 16-bit management interrupt status with a mask. Status bits are set by event inputs and cleared when status is read. The register port is a plain single-cycle strobe interface: reads are combinational and writes take effect at the clock edge. There is no back-pressure.

Top module: `mii_mgmt_ctrl`

## Requirements
- R1: Registers are selected by word index: 0 frame, 1 configuration, 2 interrupt mask, 3 interrupt status. After reset they read 0x00000000, 0x00000100, 0x0000FFFF and 0x00000000. MDC, MDIO output-enable and the interrupt output are all low.
- R2: A frame is valid when bits 31:30 are 01, bits 27:23 equal PHY_ADDR (default 1), and bits 29:28 are 01 (write) or 10 (read). Any other frame is stored with bit 16 set and produces no MDC edge.
- R3: A valid frame sends 64 bits MSB first: 32 ones, then frame bits 31:18, then 1 and 0, then frame bits 15:0. MDC has a period of MDC_DIV clocks, and MDIO changes only after a falling MDC edge.
- R4: When a valid frame is accepted, it is stored with bit 16 cleared. Bit 16 is set when the 64th bit time ends.
- R5: For a read, MDIO output-enable is low from bit time 46 to the end, which covers 2 turnaround bits and 16 data bits. The 16 data bits are sampled on rising MDC edges, MSB first, and written into frame bits 15:0. Bits 31:17 are kept.
- R6: A frame-register write during a transaction leaves the register unchanged and raises the error output for exactly one cycle.
- R7: Configuration bits 9:8 ignore writes; bit 8 is 1 from reset. All other configuration bits are read/write.
- R8: Event inputs are ORed into the interrupt status. A status read returns the current value and then clears it. An event arriving in the same cycle as the read is kept. Writes to the status register are ignored.
- R9: The interrupt output is high when any status bit is set whose mask bit is 0. The mask holds 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status when index 3) |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| irq_evt | input | 16 | Interrupt event pulses, one per status bit |
| irq | output | 1 | Masked interrupt request |
| mgmt_err | output | 1 | One-cycle pulse on a frame write while busy |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO input from the pad |
| mdio_o | output | 1 | MDIO output to the pad |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The embedded assertions check the following on every cycle:
- MDC stays low while idle.
- MDIO moves only right after a falling MDC edge.
- Every end of a transaction leaves bit 16 set.
- Rejected frames start no transaction.
- A write while busy pulses the error and freezes the frame register.
- The presence bits survive configuration writes.
- A status read with no new events leaves zero.

Only the bench scenarios can show the following:
- The exact 64-bit wire pattern and the MDC period.
- The count of released bit times on a read.
- The PHY's reply landing in bits 15:0.
- Masking of the interrupt.
- An event that coincides with a status read being kept.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;
  localparam int REG_AW  = 2;
  localparam int IRQ_W   = 16;
  localparam int BITS_W  = 6;

  localparam logic [REG_AW-1:0] REG_FRAME = 2'd0;
  localparam logic [REG_AW-1:0] REG_CFG   = 2'd1;
  localparam logic [REG_AW-1:0] REG_IMASK = 2'd2;
  localparam logic [REG_AW-1:0] REG_ISTAT = 2'd3;

  localparam logic [1:0] ST_OK     = 2'b01;
  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;

  localparam logic [BITS_W-1:0] IDX_TA     = 6'd46;
  localparam logic [BITS_W-1:0] IDX_RDDATA = 6'd48;
  localparam logic [BITS_W-1:0] IDX_LAST   = 6'd63;

  localparam logic [31:0] TA_LSB   = 32'h0001_0000;
  localparam logic [31:0] CFG_RO   = 32'h0000_0300;
  localparam logic [31:0] CFG_RST  = 32'h0000_0100;
endpackage

// File: rtl/mii_mdc_gen.sv
module mii_mdc_gen #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise,
  output logic fall
);
  localparam int HALF = (DIV < 2) ? 1 : DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(HALF - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = run && (cnt == CNT_TOP);
  assign rise = wrap && !mdc;
  assign fall = wrap && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (wrap) begin
      cnt <= '0;
      mdc <= !mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3: clock parks low whenever no transaction runs
  a_r3_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc);
endmodule

// File: rtl/mii_frame_shifter.sv
module mii_frame_shifter
  import mii_mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [13:0] hdr,
  input  logic [15:0] wdat,
  input  logic        rise,
  input  logic        fall,
  input  logic        mdc,
  input  logic        mdio_i,
  output logic        busy,
  output logic        done,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic [15:0] rd_data
);
  logic [BITS_W-1:0] idx;
  logic [13:0]       hdr_q;
  logic [15:0]       dat_q;
  logic              is_rd;
  logic [15:0]       rd_sh;
  logic [63:0]       tx_vec;

  assign tx_vec  = {32'hFFFF_FFFF, hdr_q, 2'b10, dat_q};
  assign mdio_o  = busy ? tx_vec[IDX_LAST - idx] : 1'b1;
  assign mdio_oe = busy && !(is_rd && (idx >= IDX_TA));
  assign done    = busy && fall && (idx == IDX_LAST);
  assign rd_data = rd_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      hdr_q <= '0;
      dat_q <= '0;
      is_rd <= 1'b0;
      rd_sh <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        idx   <= '0;
        hdr_q <= hdr;
        dat_q <= wdat;
        is_rd <= (hdr[11:10] == OPC_READ);
      end
    end else begin
      if (rise && is_rd && (idx >= IDX_RDDATA))
        rd_sh <= {rd_sh[14:0], mdio_i};
      if (fall) begin
        if (idx == IDX_LAST) busy <= 1'b0;
        else                 idx  <= idx + 1'b1;
      end
    end
  end

  // R3: data line moves only right after a falling clock edge
  a_r3_mdio_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (mdio_o != $past(mdio_o))) |-> $fell(mdc));
endmodule

// File: rtl/mii_irq_block.sv
module mii_irq_block
  import mii_mgmt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] evt,
  input  logic             mask_we,
  input  logic [IRQ_W-1:0] mask_wdata,
  input  logic             stat_rd,
  output logic [IRQ_W-1:0] stat,
  output logic [IRQ_W-1:0] mask,
  output logic             irq
);
  assign irq = |(stat & ~mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat <= '0;
      mask <= '1;
    end else begin
      stat <= (stat & ~{IRQ_W{stat_rd}}) | evt;
      if (mask_we) mask <= mask_wdata;
    end
  end

  // R8: a status read with no new event leaves status empty
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && (evt == '0)) |=> (stat == '0));
endmodule

// File: rtl/mii_mgmt_ctrl.sv
module mii_mgmt_ctrl
  import mii_mgmt_pkg::*;
#(
  parameter int         MDC_DIV  = 8,
  parameter logic [4:0] PHY_ADDR = 5'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [IRQ_W-1:0]  irq_evt,
  output logic              irq,
  output logic              mgmt_err,
  output logic              mdc,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe
);
  logic [31:0]      frame_q;
  logic [31:0]      cfg_q;
  logic             busy, done, start;
  logic             rise, fall;
  logic             wr_frame, frm_ok;
  logic [15:0]      rd_data;
  logic [IRQ_W-1:0] stat, mask;

  assign wr_frame = reg_wr && (reg_addr == REG_FRAME);
  assign frm_ok   = (reg_wdata[31:30] == ST_OK) &&
                    (reg_wdata[27:23] == PHY_ADDR) &&
                    ((reg_wdata[29:28] == OPC_WRITE) || (reg_wdata[29:28] == OPC_READ));
  assign start    = wr_frame && !busy && frm_ok;

  mii_mdc_gen #(.DIV(MDC_DIV)) u_mdc (
    .clk(clk), .rst_n(rst_n), .run(busy), .mdc(mdc), .rise(rise), .fall(fall)
  );

  mii_frame_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .start(start),
    .hdr(reg_wdata[31:18]), .wdat(reg_wdata[15:0]),
    .rise(rise), .fall(fall), .mdc(mdc), .mdio_i(mdio_i),
    .busy(busy), .done(done), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .rd_data(rd_data)
  );

  mii_irq_block u_irq (
    .clk(clk), .rst_n(rst_n), .evt(irq_evt),
    .mask_we(reg_wr && (reg_addr == REG_IMASK)),
    .mask_wdata(reg_wdata[IRQ_W-1:0]),
    .stat_rd(reg_rd && (reg_addr == REG_ISTAT)),
    .stat(stat), .mask(mask), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q  <= '0;
      cfg_q    <= CFG_RST;
      mgmt_err <= 1'b0;
    end else begin
      mgmt_err <= wr_frame && busy;
      if (wr_frame && !busy) begin
        frame_q <= frm_ok ? (reg_wdata & ~TA_LSB) : (reg_wdata | TA_LSB);
      end else if (done) begin
        frame_q[16] <= 1'b1;
        if (frame_q[29:28] == OPC_READ) frame_q[15:0] <= rd_data;
      end
      if (reg_wr && (reg_addr == REG_CFG))
        cfg_q <= (reg_wdata & ~CFG_RO) | (cfg_q & CFG_RO);
    end
  end

  always_comb begin
    case (reg_addr)
      REG_FRAME: reg_rdata = frame_q;
      REG_CFG:   reg_rdata = cfg_q;
      REG_IMASK: reg_rdata = {{(32-IRQ_W){1'b0}}, mask};
      default:   reg_rdata = {{(32-IRQ_W){1'b0}}, stat};
    endcase
  end

  // R4: the end of every transaction leaves the turnaround LSB set
  a_r4_done_sets_ta: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> frame_q[16]);

  // R2: rejected frames complete at once with no bus activity
  a_r2_reject_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_frame && !busy && !frm_ok) |=> (!busy && frame_q[16]));

  // R6: write while busy is dropped and flagged
  a_r6_busy_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_frame && busy && !done) |=> (mgmt_err && $stable(frame_q)));

  // R7: presence bits survive configuration writes
  a_r7_presence_ro: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == REG_CFG)) |=> (cfg_q[9:8] == $past(cfg_q[9:8])));
endmodule

// File: tb/test_mii_mgmt_ctrl.sv
module test_mii_mgmt_ctrl;
  localparam int CLK_NS = 10;
  localparam int DIV    = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] irq_evt = '0;
  logic        irq, mgmt_err, mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  always #(CLK_NS/2) clk = ~clk;

  mii_mgmt_ctrl #(.MDC_DIV(DIV), .PHY_ADDR(5'd1)) i_mii_mgmt_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_evt(irq_evt), .irq(irq), .mgmt_err(mgmt_err), .mdc(mdc),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // scoreboard
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        sb_rd = 1'b0;
  logic [31:0] mon_e;
  string       mon_t;

  always @(negedge clk) begin
    #2;
    if (sb_rd && reg_rd) begin
      if (exp_q.size() == 0) check(1'b0, "scoreboard empty", 64'(reg_rdata), 64'h0);
      else begin
        mon_e = exp_q.pop_front();
        mon_t = tag_q.pop_front();
        check(reg_rdata === mon_e, mon_t, 64'(reg_rdata), 64'(mon_e));
      end
    end
  end

  // PHY model
  logic [15:0] phy_word = 16'h0;
  int          k = 0, oe_bits = 0, rises = 0;
  logic [63:0] cap = '0;
  time         last_rise = 0, mdc_per = 0;

  always @(posedge mdc) begin
    if (k == 0) oe_bits = 0;
    if (mdio_oe) oe_bits++;
    cap[63-k] = mdio_o;
    if (last_rise != 0) mdc_per = $time - last_rise;
    last_rise = $time;
    rises++;
    k = (k + 1) % 64;
  end

  always @(negedge mdc) mdio_i = (k >= 48) ? phy_word[63-k] : 1'b1;

  task automatic bus_wr(input logic [1:0] a, input logic [31:0] d, output bit err);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0; err = mgmt_err;
  endtask

  task automatic sb_read(input logic [1:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; sb_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; sb_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1; v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < 3000 && !v[16]; i++) peek(2'd0, v);
    if (!v[16]) check(1'b0, tag, 64'(v), 64'h10000);
  endtask

  task automatic pulse_evt(input logic [15:0] e);
    @(negedge clk); irq_evt = e;
    @(negedge clk); irq_evt = '0;
  endtask

  logic [31:0] w, r, b;
  bit          err;
  int          r0;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check(mdc == 1'b0 && mdio_oe == 1'b0 && irq == 1'b0, "R1 pins idle",
          64'({mdc, mdio_oe, irq}), 64'h0);
    sb_read(2'd0, 32'h0, "R1 frame reset");
    sb_read(2'd1, 32'h100, "R1 cfg reset");
    sb_read(2'd2, 32'hFFFF, "R1 mask reset");
    sb_read(2'd3, 32'h0, "R1 status reset");

    // R3/R4 write transaction
    w = 32'h50FD_1234;
    bus_wr(2'd0, w, err);
    sb_read(2'd0, w & ~32'h10000, "R4 bit16 cleared while running");
    wait_done("R4 write completion");
    check(cap == {32'hFFFF_FFFF, w[31:18], 2'b10, w[15:0]}, "R3 wire pattern",
          cap, {32'hFFFF_FFFF, w[31:18], 2'b10, w[15:0]});
    check(mdc_per == DIV*CLK_NS, "R3 mdc period", 64'(mdc_per), 64'(DIV*CLK_NS));
    sb_read(2'd0, w | 32'h10000, "R4 bit16 set at end");

    // R5 read transaction
    phy_word = 16'hA5C3;
    r = 32'h6094_BEEF;
    bus_wr(2'd0, r, err);
    wait_done("R5 read completion");
    check(oe_bits == 46, "R5 driven bit count", 64'(oe_bits), 64'd46);
    sb_read(2'd0, {r[31:17], 1'b1, 16'hA5C3}, "R5 read data");

    // R2 rejected frames
    b = 32'h1094_0000; r0 = rises;
    bus_wr(2'd0, b, err);
    repeat (DIV*4) @(negedge clk);
    check(rises == r0, "R2 bad start no mdc", 64'(rises), 64'(r0));
    sb_read(2'd0, b | 32'h10000, "R2 bad start stored");
    b = 32'h6114_0000; r0 = rises;
    bus_wr(2'd0, b, err);
    repeat (DIV*4) @(negedge clk);
    check(rises == r0, "R2 other phy no mdc", 64'(rises), 64'(r0));
    sb_read(2'd0, b | 32'h10000, "R2 other phy stored");
    b = 32'h7094_0000; r0 = rises;
    bus_wr(2'd0, b, err);
    repeat (DIV*4) @(negedge clk);
    check(rises == r0, "R2 bad opcode no mdc", 64'(rises), 64'(r0));
    sb_read(2'd0, b | 32'h10000, "R2 bad opcode stored");

    // R6 write while busy
    w = 32'h5084_0055;
    bus_wr(2'd0, w, err);
    check(err == 1'b0, "R6 no error when idle", 64'(err), 64'h0);
    repeat (10) @(negedge clk);
    bus_wr(2'd0, 32'h6094_0000, err);
    check(err == 1'b1, "R6 error pulse", 64'(err), 64'h1);
    @(negedge clk);
    check(mgmt_err == 1'b0, "R6 pulse one cycle", 64'(mgmt_err), 64'h0);
    wait_done("R6 completion");
    sb_read(2'd0, w | 32'h10000, "R6 frame kept");

    // R7 config
    bus_wr(2'd1, 32'hFFFF_FFFF, err);
    sb_read(2'd1, 32'hFFFF_FDFF, "R7 presence bits ignore ones");
    bus_wr(2'd1, 32'h0, err);
    sb_read(2'd1, 32'h100, "R7 presence bits ignore zeros");

    // R8/R9 interrupts
    pulse_evt(16'h0008);
    check(irq == 1'b0, "R9 masked event", 64'(irq), 64'h0);
    sb_read(2'd3, 32'h8, "R8 status set");
    sb_read(2'd3, 32'h0, "R8 read clears");
    bus_wr(2'd3, 32'hFFFF, err);
    sb_read(2'd3, 32'h0, "R8 status write ignored");
    bus_wr(2'd2, 32'hFFF7, err);
    sb_read(2'd2, 32'hFFF7, "R9 mask write");
    pulse_evt(16'h0009);
    check(irq == 1'b1, "R9 unmasked event", 64'(irq), 64'h1);
    sb_read(2'd3, 32'h9, "R8 status two bits");
    check(irq == 1'b0, "R9 irq drops after read", 64'(irq), 64'h0);
    exp_q.push_back(32'h0); tag_q.push_back("R8 read with coincident event");
    @(negedge clk); reg_rd = 1'b1; reg_addr = 2'd3; sb_rd = 1'b1; irq_evt = 16'h0020;
    @(negedge clk); reg_rd = 1'b0; sb_rd = 1'b0; irq_evt = '0;
    sb_read(2'd3, 32'h20, "R8 coincident event kept");

    repeat (4) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_NS*150000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule